// File: doc/BRIEF.md
# Multi-Bank Selectable Clock Divider

This block turns one fast source clock into three banks of four divided clocks plus one feedback clock. Each bank and the feedback path owns a divider whose ratio comes from its own select field. A pre-divide stage can halve the source ahead of the dividers. A bypass path lets a reference clock drive the dividers directly, and that path skips the pre-divide stage. The two upper outputs of bank C can be inverted.

The block runs in a core clock domain. The source and the reference arrive as clock-level inputs that are oversampled by the core clock, and every rising edge of the selected input is one divider step. An active-low master reset clears every divider, drives all outputs low and drops every output enable. While the reset is held, the block also captures the select fields, so a new ratio takes effect only through a reset. On release, every divider steps on the same input edge, which makes all first rising edges coincide.

Top module: `clkdiv_banks`

## Requirements
- R1: Bank A divides by 4, 6, 8, 12 for select codes 00, 01, 10, 11.
- R2: Bank B divides by 4, 6, 8, 10 for select codes 00, 01, 10, 11.
- R3: Bank C divides by 2, 4, 6, 8 for select codes 00, 01, 10, 11.
- R4: The feedback output divides by 4, 6, 8, 10, 8, 12, 16, 20 for the 3-bit select codes 000 through 111.
- R5: In PLL mode (`pll_sel` = 1), `vco_full` = 0 halves the source before the dividers, and `vco_full` = 1 passes it through undivided.
- R6: With `pll_sel` = 0, the dividers count rising edges of `ref_clk`, and the pre-divide stage has no effect.
- R7: While `mr_n` is low, all clock outputs are low and `out_en` is all zeros. `out_en` is all ones from the second clock edge after `mr_n` rises.
- R8: With `inv_c` = 1 and outputs enabled, copies 2 and 3 of bank C are the complement of copies 0 and 1. Copies 0 and 1 are never inverted.
- R9: Every output has a 50% duty cycle: its high time is half its period.
- R10: After reset release, the first rising edges of every non-inverted output fall in the same core cycle.
- R11: A change on any select field while `mr_n` is high leaves the running ratios unchanged until the next reset.
- R12: All copies of one bank carry the same waveform, apart from the inversion in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that oversamples the source and reference |
| mr_n | input | 1 | Active-low master reset and output enable; captures the selects while low |
| src_clk | input | 1 | Fast source clock level |
| ref_clk | input | 1 | Reference clock level used in bypass |
| vco_full | input | 1 | 1: source undivided, 0: source halved |
| pll_sel | input | 1 | 1: source path, 0: reference bypass |
| inv_c | input | 1 | Inverts bank C copies 2 and 3 |
| sel_a | input | 2 | Bank A ratio select |
| sel_b | input | 2 | Bank B ratio select |
| sel_c | input | 2 | Bank C ratio select |
| sel_fb | input | 3 | Feedback ratio select |
| qa | output | 4 | Bank A clocks |
| qb | output | 4 | Bank B clocks |
| qc | output | 4 | Bank C clocks |
| qfb | output | 1 | Feedback clock |
| out_en | output | 13 | Per-output enable: bits 0-3 bank A, 4-7 bank B, 8-11 bank C, 12 feedback |

## Verification
A down-counter that is off by one shows up as a wrong period on the next output edge, within one output period of reset release. A wrong reload value gives an asymmetric high or low time within the same period. A pre-divide phase that is not cleared, or a tick that is not shared by all dividers, moves the first rising edges apart in the cycles right after release. A configuration register that follows the select pins changes a measured period without any reset.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int HALF_W = 4;

    typedef struct packed {
        logic       vco_full;
        logic       use_pll;
        logic [1:0] sel_a;
        logic [1:0] sel_b;
        logic [1:0] sel_c;
        logic [2:0] sel_fb;
    } cfg_t;

    // Half ratios: the output toggles once every "half" input steps.
    function automatic logic [HALF_W-1:0] half_a(input logic [1:0] s);
        case (s)
            2'b00:   return 4'd2;
            2'b01:   return 4'd3;
            2'b10:   return 4'd4;
            default: return 4'd6;
        endcase
    endfunction

    function automatic logic [HALF_W-1:0] half_b(input logic [1:0] s);
        case (s)
            2'b00:   return 4'd2;
            2'b01:   return 4'd3;
            2'b10:   return 4'd4;
            default: return 4'd5;
        endcase
    endfunction

    function automatic logic [HALF_W-1:0] half_c(input logic [1:0] s);
        return {2'b00, s} + 4'd1;
    endfunction

    function automatic logic [HALF_W-1:0] half_fb(input logic [2:0] s);
        case (s)
            3'b000:  return 4'd2;
            3'b001:  return 4'd3;
            3'b010:  return 4'd4;
            3'b011:  return 4'd5;
            3'b100:  return 4'd4;
            3'b101:  return 4'd6;
            3'b110:  return 4'd8;
            default: return 4'd10;
        endcase
    endfunction

endpackage

// File: rtl/clkdiv_tick.sv
module clkdiv_tick (
    input  logic clk,
    input  logic mr_n,
    input  logic src_clk,
    input  logic ref_clk,
    input  logic vco_full,
    input  logic use_pll,
    output logic tick
);

    typedef struct packed {
        logic src1;
        logic src2;
        logic ref1;
        logic ref2;
        logic ph;
    } tick_st_t;

    tick_st_t st_d, st_q;
    logic     src_rise, ref_rise;

    always_comb begin
        st_d      = st_q;
        src_rise  = st_q.src1 & ~st_q.src2;
        ref_rise  = st_q.ref1 & ~st_q.ref2;
        st_d.src1 = src_clk;
        st_d.src2 = st_q.src1;
        st_d.ref1 = ref_clk;
        st_d.ref2 = st_q.ref1;
        if (src_rise) begin
            st_d.ph = ~st_q.ph;
        end
        if (!mr_n) begin
            st_d.ph = 1'b0;
        end
        if (!mr_n) begin
            tick = 1'b0;
        end else if (!use_pll) begin
            tick = ref_rise;
        end else if (vco_full) begin
            tick = src_rise;
        end else begin
            tick = src_rise & ~st_q.ph;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

endmodule

// File: rtl/clkdiv_cell.sv
module clkdiv_cell #(
    parameter int HALF_W = 4
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              tick,
    input  logic [HALF_W-1:0] half,
    output logic              clk_out
);

    typedef struct packed {
        logic [HALF_W-1:0] cnt;
        logic              lvl;
    } cell_st_t;

    cell_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick) begin
            if (st_q.cnt == '0) begin
                st_d.lvl = ~st_q.lvl;
                st_d.cnt = half - {{(HALF_W-1){1'b0}}, 1'b1};
            end else begin
                st_d.cnt = st_q.cnt - {{(HALF_W-1){1'b0}}, 1'b1};
            end
        end
        if (clr) begin
            st_d.cnt = '0;
            st_d.lvl = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign clk_out = st_q.lvl;

endmodule

// File: rtl/clkdiv_banks.sv
module clkdiv_banks #(
    parameter int COPIES    = 4,
    parameter int INV_FIRST = 2
) (
    input  logic                  clk,
    input  logic                  mr_n,
    input  logic                  src_clk,
    input  logic                  ref_clk,
    input  logic                  vco_full,
    input  logic                  pll_sel,
    input  logic                  inv_c,
    input  logic [1:0]            sel_a,
    input  logic [1:0]            sel_b,
    input  logic [1:0]            sel_c,
    input  logic [2:0]            sel_fb,
    output logic [COPIES-1:0]     qa,
    output logic [COPIES-1:0]     qb,
    output logic [COPIES-1:0]     qc,
    output logic                  qfb,
    output logic [3*COPIES:0]     out_en
);
    import clkdiv_pkg::*;

    localparam int N_OUT = 3 * COPIES + 1;
    localparam int N_DIV = 4;

    typedef struct packed {
        cfg_t             cfg;
        logic [N_OUT-1:0] en;
    } top_st_t;

    top_st_t            st_d, st_q;
    cfg_t               cfg_q;
    logic               tick;
    logic [HALF_W-1:0]  half_v [N_DIV];
    logic [N_DIV-1:0]   raw;

    always_comb begin
        st_d = st_q;
        st_d.en = {N_OUT{mr_n}};
        if (!mr_n) begin
            st_d.cfg.vco_full = vco_full;
            st_d.cfg.use_pll  = pll_sel;
            st_d.cfg.sel_a    = sel_a;
            st_d.cfg.sel_b    = sel_b;
            st_d.cfg.sel_c    = sel_c;
            st_d.cfg.sel_fb   = sel_fb;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cfg_q     = st_q.cfg;
    assign half_v[0] = half_a(cfg_q.sel_a);
    assign half_v[1] = half_b(cfg_q.sel_b);
    assign half_v[2] = half_c(cfg_q.sel_c);
    assign half_v[3] = half_fb(cfg_q.sel_fb);

    clkdiv_tick u_tick (
        .clk      (clk),
        .mr_n     (mr_n),
        .src_clk  (src_clk),
        .ref_clk  (ref_clk),
        .vco_full (cfg_q.vco_full),
        .use_pll  (cfg_q.use_pll),
        .tick     (tick)
    );

    for (genvar k = 0; k < N_DIV; k++) begin : g_div
        clkdiv_cell #(.HALF_W(HALF_W)) u_cell (
            .clk     (clk),
            .clr     (~mr_n),
            .tick    (tick),
            .half    (half_v[k]),
            .clk_out (raw[k])
        );
    end

    for (genvar i = 0; i < COPIES; i++) begin : g_fan
        assign qa[i] = raw[0];
        assign qb[i] = raw[1];
        if (i >= INV_FIRST) begin : g_inv
            assign qc[i] = raw[2] ^ (inv_c & st_q.en[2*COPIES+i]);
        end else begin : g_plain
            assign qc[i] = raw[2];
        end
    end

    assign qfb    = raw[3];
    assign out_en = st_q.en;

endmodule

// File: rtl/clkdiv_banks_chk.sv
module clkdiv_banks_chk #(
    parameter int COPIES = 4
) (
    input logic                  clk,
    input logic                  mr_n,
    input logic                  inv_c,
    input logic [COPIES-1:0]     qa,
    input logic [COPIES-1:0]     qc,
    input logic                  qfb,
    input logic [3*COPIES:0]     out_en,
    input clkdiv_pkg::cfg_t      cfg_q
);

    assert_reset_quiet_R7: assert property (@(posedge clk)
        !mr_n |=> (out_en == '0 && qa == '0 && qc == '0 && qfb == 1'b0));

    assert_enable_on_R7: assert property (@(posedge clk) disable iff (!mr_n)
        mr_n |=> (&out_en));

    assert_inv_pair_R8: assert property (@(posedge clk) disable iff (!mr_n)
        (out_en[3*COPIES-1] && inv_c) |-> (qc[COPIES-1] != qc[0]));

    assert_plain_pair_R8: assert property (@(posedge clk) disable iff (!mr_n)
        !inv_c |-> (qc[COPIES-1] == qc[0]));

    assert_single_step_R9: assert property (@(posedge clk) disable iff (!mr_n)
        !$stable(qfb) |=> $stable(qfb));

    assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (!mr_n)
        1'b1 |=> $stable(cfg_q));

endmodule

bind clkdiv_banks clkdiv_banks_chk #(.COPIES(COPIES)) i_chk (
    .clk    (clk),
    .mr_n   (mr_n),
    .inv_c  (inv_c),
    .qa     (qa),
    .qc     (qc),
    .qfb    (qfb),
    .out_en (out_en),
    .cfg_q  (cfg_q)
);

// File: tb/test_clkdiv_banks.sv
module test_clkdiv_banks;

    typedef struct {
        int    id;
        int    per;
        string tag;
    } item_t;

    logic       clk = 1'b0;
    logic       mr_n = 1'b0;
    logic       src_clk = 1'b0;
    logic       ref_clk = 1'b0;
    logic       vco_full = 1'b1;
    logic       pll_sel = 1'b1;
    logic       inv_c = 1'b0;
    logic [1:0] sel_a = 2'b00;
    logic [1:0] sel_b = 2'b00;
    logic [1:0] sel_c = 2'b00;
    logic [2:0] sel_fb = 3'b000;
    logic [3:0] qa, qb, qc;
    logic       qfb;
    logic [12:0] out_en;

    int    n_run = 0;
    int    n_bad = 0;
    int    n_push = 0;
    int    n_done = 0;
    item_t sb [$];

    always #2 clk = ~clk;

    clkdiv_banks i_clkdiv_banks (
        .clk(clk), .mr_n(mr_n), .src_clk(src_clk), .ref_clk(ref_clk),
        .vco_full(vco_full), .pll_sel(pll_sel), .inv_c(inv_c),
        .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c), .sel_fb(sel_fb),
        .qa(qa), .qb(qb), .qc(qc), .qfb(qfb), .out_en(out_en)
    );

    // Source: period 2 core cycles. Reference: period 6 core cycles.
    initial begin
        int rc;
        rc = 0;
        forever begin
            @(negedge clk);
            src_clk = ~src_clk;
            rc++;
            if (rc == 3) begin
                ref_clk = ~ref_clk;
                rc = 0;
            end
        end
    end

    function automatic int ratio_a(input logic [1:0] s);
        case (s) 2'b00: return 4; 2'b01: return 6; 2'b10: return 8; default: return 12; endcase
    endfunction
    function automatic int ratio_b(input logic [1:0] s);
        case (s) 2'b00: return 4; 2'b01: return 6; 2'b10: return 8; default: return 10; endcase
    endfunction
    function automatic int ratio_c(input logic [1:0] s);
        case (s) 2'b00: return 2; 2'b01: return 4; 2'b10: return 6; default: return 8; endcase
    endfunction
    function automatic int ratio_fb(input logic [2:0] s);
        case (s)
            3'b000: return 4;  3'b001: return 6;  3'b010: return 8;  3'b011: return 10;
            3'b100: return 8;  3'b101: return 12; 3'b110: return 16; default: return 20;
        endcase
    endfunction

    function automatic int base_cycles();
        if (!pll_sel) return 6;
        return vco_full ? 2 : 4;
    endfunction

    function automatic logic pick(input int id);
        case (id)
            0: return qa[0];
            1: return qb[0];
            2: return qc[0];
            3: return qfb;
            4: return qc[3];
            5: return qa[3];
            6: return qb[2];
            default: return qc[1];
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(input int id, input int per, input string tag);
        item_t it;
        it.id = id; it.per = per; it.tag = tag;
        sb.push_back(it);
        n_push++;
        wait (n_done == n_push);
    endtask

    // Monitor: pops expected items and measures the matching output.
    initial begin
        forever begin
            item_t it;
            int    hi;
            int    per;
            wait (sb.size() != 0);
            it = sb.pop_front();
            @(negedge clk);
            while (pick(it.id) !== 1'b0) @(negedge clk);
            while (pick(it.id) !== 1'b1) @(negedge clk);
            hi = 0;
            while (pick(it.id) === 1'b1) begin @(negedge clk); hi++; end
            per = hi;
            while (pick(it.id) === 1'b0) begin @(negedge clk); per++; end
            check(per == it.per, {it.tag, " period"}, per, it.per);
            check(2 * hi == it.per, {it.tag, " high time R9"}, hi, it.per / 2);
            n_done++;
        end
    end

    task automatic restart(input logic [1:0] a, input logic [1:0] b, input logic [1:0] c,
                           input logic [2:0] fb, input logic vf, input logic ps, input logic iv);
        int n;
        @(negedge clk);
        mr_n = 1'b0;
        sel_a = a; sel_b = b; sel_c = c; sel_fb = fb;
        vco_full = vf; pll_sel = ps; inv_c = iv;
        repeat (3) @(negedge clk);
        check(out_en == 13'd0 && qa == 4'd0 && qb == 4'd0 && qc == 4'd0 && qfb == 1'b0,
              "R7 outputs held low in reset", {qa, qb, qc, qfb}, 0);
        mr_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(out_en == 13'h1fff, "R7 enables after release", out_en, 13'h1fff);
        n = 0;
        while (qa[0] !== 1'b1 && n < 40) begin @(negedge clk); n++; end
        check(qa[0] && qb[0] && qc[0] && qfb && qc[1],
              "R10 first edges coincide", {qa[0], qb[0], qc[0], qfb, qc[1]}, 5'b11111);
    endtask

    task automatic copies_check();
        int bad;
        bad = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (!(qa == 4'h0 || qa == 4'hf)) bad++;
            if (!(qb == 4'h0 || qb == 4'hf)) bad++;
            if (qc[0] != qc[1] || qc[2] != qc[3]) bad++;
        end
        check(bad == 0, "R12 copies identical", bad, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        n_run++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", n_done, n_push);
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        // Main ratio sweep, source undivided.
        for (int s = 0; s < 4; s++) begin
            restart(s[1:0], s[1:0], s[1:0], s[2:0], 1'b1, 1'b1, 1'b0);
            push(0, ratio_a(s[1:0]) * base_cycles(), "R1 bank A");
            push(5, ratio_a(s[1:0]) * base_cycles(), "R12 bank A copy 3");
            push(1, ratio_b(s[1:0]) * base_cycles(), "R2 bank B");
            push(6, ratio_b(s[1:0]) * base_cycles(), "R12 bank B copy 2");
            push(2, ratio_c(s[1:0]) * base_cycles(), "R3 bank C");
            push(3, ratio_fb(s[2:0]) * base_cycles(), "R4 feedback");
            copies_check();
        end
        // Upper feedback codes.
        for (int f = 4; f < 8; f++) begin
            restart(2'b00, 2'b00, 2'b00, f[2:0], 1'b1, 1'b1, 1'b0);
            push(3, ratio_fb(f[2:0]) * 2, "R4 feedback upper code");
        end
        // Pre-divide halves the source.
        restart(2'b01, 2'b10, 2'b00, 3'b001, 1'b0, 1'b1, 1'b0);
        push(0, 6 * 4, "R5 bank A halved source");
        push(2, 2 * 4, "R5 bank C halved source");
        push(3, 6 * 4, "R5 feedback halved source");
        // Bypass: reference drives the dividers, pre-divide ignored.
        restart(2'b00, 2'b11, 2'b00, 3'b000, 1'b0, 1'b0, 1'b0);
        push(0, 4 * 6, "R6 bank A bypass");
        push(1, 10 * 6, "R6 bank B bypass");
        push(2, 2 * 6, "R6 bank C bypass");
        restart(2'b00, 2'b00, 2'b01, 3'b000, 1'b1, 1'b0, 1'b0);
        push(2, 4 * 6, "R6 bank C bypass with full source");
        // Inversion of bank C upper copies.
        restart(2'b00, 2'b00, 2'b01, 3'b000, 1'b1, 1'b1, 1'b1);
        push(4, 4 * 2, "R8 inverted copy period");
        push(7, 4 * 2, "R8 plain copy period");
        begin
            int bad;
            bad = 0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (qc[2] == qc[0] || qc[3] == qc[1] || qc[1] != qc[0]) bad++;
            end
            check(bad == 0, "R8 copies 2,3 inverted and 0,1 plain", bad, 0);
        end
        inv_c = 1'b0;
        @(negedge clk);
        check(qc[3] == qc[0], "R8 inversion off", qc[3], qc[0]);
        // Select changes without reset are ignored.
        restart(2'b00, 2'b00, 2'b00, 3'b000, 1'b1, 1'b1, 1'b0);
        sel_a = 2'b11; sel_c = 2'b11; sel_fb = 3'b111; vco_full = 1'b0; pll_sel = 1'b0;
        push(0, 4 * 2, "R11 bank A keeps ratio");
        push(2, 2 * 2, "R11 bank C keeps ratio");
        push(3, 4 * 2, "R11 feedback keeps ratio");
        restart(2'b11, 2'b00, 2'b11, 3'b111, 1'b1, 1'b1, 1'b0);
        push(0, 12 * 2, "R11 bank A new ratio after reset");
        copies_check();
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

endmodule